// File: doc/BRIEF.md
# Keyed Indirect Configuration Register Space

This block holds the configuration registers of a multi-function peripheral controller. The host reaches it through two byte-wide ports on an 8-bit I/O bus. One port selects a register, and the other reads or writes the selected register. The register space stays sealed until the host writes a two-byte key to the select port. A dedicated exit byte seals it again. While it is sealed, reads return all ones and writes change nothing.

Once the space is open, select values below 0x30 reach a small global area. This area holds a soft-reset trigger, the port-pair control for the general-purpose I/O block, and the logical-device number. Select values from 0x30 upward reach the bank of the logical device that was last chosen. Each bank drives the enable, 16-bit base address, two interrupt numbers, DMA channel and a row of mode bytes of one peripheral.

Top module: `cfg_space_top`

## Requirements
- R1: After reset the space is sealed. Writing 0x51 and then 0x23 to the select port (bus_port = 0) opens it. Right after opening, the select port reads back 0x00.
- R2: Key progress is lost when, after 0x51, the next write is any other select-port value or any write to the value port (bus_port = 1). The sequence 0x51, 0x00, 0x23 leaves the space sealed. A repeated 0x51 keeps the progress, so 0x51, 0x51, 0x23 opens the space.
- R3: While sealed, both ports read 0xFF, and writes to the value port change no register or output.
- R4: In the open state, writing 0xBB to the select port seals the space and leaves the held select value unchanged. After the space is reopened, the select port reads that value again.
- R5: In the open state, a select-port write of any other value becomes the current register select, and reading the select port returns it. A value-port write stores into the selected register.
- R6: Global register 0x07 holds the device number, with reset value 0. Banked writes reach only the bank with that number. A number of NUM_DEV or more drops banked writes, and banked reads then return 0x00.
- R7: In a bank, 0x30 bit 0 drives dev_active and reads back with bits 7:1 as zero. 0x60 and 0x61 are the high and low bytes of dev_base. 0x70 drives dev_irq, 0x72 drives dev_irq2 and 0x74 drives dev_dma. Device d owns slice [d*16 +: 16] of dev_base and slice [d*8 +: 8] of the byte outputs.
- R8: Bank registers 0xF0 to 0xF4 are 8-bit mode bytes. Mode byte m of device d drives dev_mode[(d*NUM_MODE+m)*8 +: 8] and reads back. An unmapped bank register such as 0xF5 reads 0x00.
- R9: Global register 0x03 keeps only bits 7 and 1:0. Bits 1:0 drive gio_port_sel and bit 7 drives gio_port_en. A readback shows the other bits as zero.
- R10: Writing a value with bit 0 set to global register 0x02 returns every global and bank register to its reset value (dev_dma = 0x04, all others 0) and leaves the space open. A value with bit 0 clear has no effect. The register reads 0x00.
- R11: Hardware reset clears every register to the same reset values: dev_dma = 0x04 and all other outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_port | input | 1 | 0 = select port, 1 = value port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| dev_active | output | NUM_DEV | Per-device enable |
| dev_base | output | NUM_DEV*16 | Per-device base address |
| dev_irq | output | NUM_DEV*8 | Per-device primary interrupt number |
| dev_irq2 | output | NUM_DEV*8 | Per-device second interrupt number |
| dev_dma | output | NUM_DEV*8 | Per-device DMA channel |
| dev_mode | output | NUM_DEV*NUM_MODE*8 | Per-device mode bytes |
| gio_port_sel | output | 2 | General-purpose I/O port-pair select |
| gio_port_en | output | 1 | General-purpose I/O port-pair enable |

## Verification
The bench builds the block with its default parameters: nine devices, five mode bytes and the second-interrupt variant present. Nine banks put device 8, the highest bank, in reach, and the device number 9 tests a select just past the last bank. The five mode bytes end at 0xF4, so 0xF5 is the first unmapped bank register.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
   typedef enum logic [1:0] {
      KS_SEALED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam logic       PORT_SEL   = 1'b0;
   localparam logic       PORT_VAL   = 1'b1;

   localparam logic [7:0] G_SRST     = 8'h02;
   localparam logic [7:0] G_GIO      = 8'h03;
   localparam logic [7:0] G_DEVNUM   = 8'h07;
   localparam logic [7:0] BANK_FIRST = 8'h30;

   localparam logic [7:0] B_ACT      = 8'h30;
   localparam logic [7:0] B_BASE_HI  = 8'h60;
   localparam logic [7:0] B_BASE_LO  = 8'h61;
   localparam logic [7:0] B_IRQ      = 8'h70;
   localparam logic [7:0] B_IRQ2     = 8'h72;
   localparam logic [7:0] B_DMA      = 8'h74;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
   import cfgspace_pkg::*;
#(
   parameter logic [7:0] KEY_A    = 8'h51,
   parameter logic [7:0] KEY_B    = 8'h23,
   parameter logic [7:0] EXIT_VAL = 8'hBB
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       port,
   input  logic [7:0] wdata,
   output logic       open,
   output logic [7:0] sel,
   output logic       val_wr
);
   if (KEY_A == KEY_B || KEY_A == EXIT_VAL) begin : g_bad_keys
      initial $fatal(1, "cfg_port_ctrl: key bytes must differ from each other and from the exit byte");
   end

   key_state_e state_q;
   logic [7:0] sel_q;
   logic       sel_wr;

   assign sel_wr = wr && (port == PORT_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KS_SEALED;
         sel_q   <= 8'h00;
      end else begin
         case (state_q)
            KS_SEALED: begin
               if (sel_wr && wdata == KEY_A) state_q <= KS_HALF;
            end
            KS_HALF: begin
               if (wr) begin
                  if (sel_wr && wdata == KEY_B)      state_q <= KS_OPEN;
                  else if (sel_wr && wdata == KEY_A) state_q <= KS_HALF;
                  else                               state_q <= KS_SEALED;
               end
            end
            KS_OPEN: begin
               if (sel_wr) begin
                  if (wdata == EXIT_VAL) state_q <= KS_SEALED;
                  else                   sel_q   <= wdata;
               end
            end
            default: state_q <= KS_SEALED;
         endcase
      end
   end

   assign open   = (state_q == KS_OPEN);
   assign sel    = sel_q;
   assign val_wr = open && wr && (port == PORT_VAL);

   // R1: opening follows a second key byte on the select port
   a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(sel_wr && wdata == KEY_B));

   // R4: the exit byte seals and keeps the select value
   a_r4_exit_seals: assert property (@(posedge clk) disable iff (!rst_n)
      (open && sel_wr && wdata == EXIT_VAL) |=> (!open && $stable(sel)));

   // R3: the select value does not move while sealed
   a_r3_sealed_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(sel));
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import cfgspace_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] sel,
   input  logic [7:0] wdata,
   output logic       srst,
   output logic [7:0] dev_num,
   output logic [1:0] gio_sel,
   output logic       gio_en,
   output logic [7:0] rd_data
);
   logic [7:0] dev_num_q;
   logic [1:0] gio_sel_q;
   logic       gio_en_q;

   assign srst = wr && (sel == G_SRST) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_num_q <= 8'h00;
         gio_sel_q <= 2'b00;
         gio_en_q  <= 1'b0;
      end else if (srst) begin
         dev_num_q <= 8'h00;
         gio_sel_q <= 2'b00;
         gio_en_q  <= 1'b0;
      end else if (wr) begin
         if (sel == G_DEVNUM) dev_num_q <= wdata;
         if (sel == G_GIO) begin
            gio_sel_q <= wdata[1:0];
            gio_en_q  <= wdata[7];
         end
      end
   end

   always_comb begin
      case (sel)
         G_GIO:    rd_data = {gio_en_q, 5'b00000, gio_sel_q};
         G_DEVNUM: rd_data = dev_num_q;
         default:  rd_data = 8'h00;
      endcase
   end

   assign dev_num = dev_num_q;
   assign gio_sel = gio_sel_q;
   assign gio_en  = gio_en_q;

   // R10: a soft reset returns the device number to zero
   a_r10_srst_devnum: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (dev_num == 8'h00 && !gio_en));

   // R9: the port-pair control follows a write to its register
   a_r9_gio_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == G_GIO) |=> (gio_sel == $past(wdata[1:0]) && gio_en == $past(wdata[7])));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
   import cfgspace_pkg::*;
#(
   parameter int         NUM_MODE  = 5,
   parameter logic [7:0] MODE_BASE = 8'hF0,
   parameter logic [7:0] DMA_RST   = 8'h04,
   parameter bit         HAS_IRQ2  = 1'b1,
   localparam int        MODE_W    = NUM_MODE * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              wr,
   input  logic [7:0]        sel,
   input  logic [7:0]        wdata,
   output logic              active,
   output logic [15:0]       base,
   output logic [7:0]        irq,
   output logic [7:0]        irq2,
   output logic [7:0]        dma,
   output logic [MODE_W-1:0] mode,
   output logic [7:0]        rd_data
);
   logic       act_q;
   logic [7:0] base_hi_q, base_lo_q, irq_q, dma_q;
   logic [7:0] irq2_rd;
   logic [7:0] mode_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         base_hi_q <= 8'h00;
         base_lo_q <= 8'h00;
         irq_q     <= 8'h00;
         dma_q     <= DMA_RST;
      end else if (srst) begin
         act_q     <= 1'b0;
         base_hi_q <= 8'h00;
         base_lo_q <= 8'h00;
         irq_q     <= 8'h00;
         dma_q     <= DMA_RST;
      end else if (wr) begin
         case (sel)
            B_ACT:     act_q     <= wdata[0];
            B_BASE_HI: base_hi_q <= wdata;
            B_BASE_LO: base_lo_q <= wdata;
            B_IRQ:     irq_q     <= wdata;
            B_DMA:     dma_q     <= wdata;
            default:   ;
         endcase
      end
   end

   if (HAS_IRQ2) begin : g_irq2
      logic [7:0] irq2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        irq2_q <= 8'h00;
         else if (srst)                     irq2_q <= 8'h00;
         else if (wr && sel == B_IRQ2)      irq2_q <= wdata;
      end
      assign irq2    = irq2_q;
      assign irq2_rd = irq2_q;
   end else begin : g_no_irq2
      assign irq2    = 8'h00;
      assign irq2_rd = 8'h00;
   end

   for (genvar m = 0; m < NUM_MODE; m++) begin : g_mode
      localparam logic [7:0] ADDR = 8'(MODE_BASE + m);
      logic [7:0] mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   mode_q <= 8'h00;
         else if (srst)                mode_q <= 8'h00;
         else if (wr && sel == ADDR)   mode_q <= wdata;
      end
      assign mode[m*8 +: 8] = mode_q;
   end

   always_comb begin
      mode_rd = 8'h00;
      for (int m = 0; m < NUM_MODE; m++) begin
         if (sel == 8'(MODE_BASE + m)) mode_rd = mode[m*8 +: 8];
      end
   end

   always_comb begin
      case (sel)
         B_ACT:     rd_data = {7'b0000000, act_q};
         B_BASE_HI: rd_data = base_hi_q;
         B_BASE_LO: rd_data = base_lo_q;
         B_IRQ:     rd_data = irq_q;
         B_IRQ2:    rd_data = irq2_rd;
         B_DMA:     rd_data = dma_q;
         default:   rd_data = mode_rd;
      endcase
   end

   assign active = act_q;
   assign base   = {base_hi_q, base_lo_q};
   assign irq    = irq_q;
   assign dma    = dma_q;

   // R3 / R6: without a write strobe or soft reset the bank holds its values
   a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !srst) |=> ($stable(base) && $stable(active) && $stable(dma) && $stable(mode)));

   // R7: the enable tracks bit 0 of a write to the activate register
   a_r7_activate: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !srst && sel == B_ACT) |=> (active == $past(wdata[0])));

   // R10: soft reset restores the DMA default
   a_r10_bank_srst: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (dma == DMA_RST && !active && base == 16'h0000));
endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
   import cfgspace_pkg::*;
#(
   parameter int         NUM_DEV   = 9,
   parameter int         NUM_MODE  = 5,
   parameter logic [7:0] MODE_BASE = 8'hF0,
   parameter logic [7:0] DMA_RST   = 8'h04,
   parameter bit         HAS_IRQ2  = 1'b1,
   parameter logic [7:0] KEY_A     = 8'h51,
   parameter logic [7:0] KEY_B     = 8'h23,
   parameter logic [7:0] EXIT_VAL  = 8'hBB,
   localparam int        MODE_W    = NUM_MODE * 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic                      bus_port,
   input  logic [7:0]                bus_wdata,
   output logic [7:0]                bus_rdata,
   output logic [NUM_DEV-1:0]        dev_active,
   output logic [NUM_DEV*16-1:0]     dev_base,
   output logic [NUM_DEV*8-1:0]      dev_irq,
   output logic [NUM_DEV*8-1:0]      dev_irq2,
   output logic [NUM_DEV*8-1:0]      dev_dma,
   output logic [NUM_DEV*MODE_W-1:0] dev_mode,
   output logic [1:0]                gio_port_sel,
   output logic                      gio_port_en
);
   if (NUM_DEV < 1 || NUM_DEV > 255) begin : g_bad_ndev
      initial $fatal(1, "cfg_space_top: NUM_DEV out of range");
   end
   if (NUM_MODE < 1 || int'(MODE_BASE) + NUM_MODE > 256 || MODE_BASE < 8'h75) begin : g_bad_mode
      initial $fatal(1, "cfg_space_top: mode window must sit above the fixed bank registers");
   end

   logic       open;
   logic [7:0] sel;
   logic       val_wr;
   logic       srst;
   logic [7:0] dev_num;
   logic [7:0] glob_rd;
   logic       glob_wr;
   logic       bank_area;
   logic [7:0] bank_rd [NUM_DEV];
   logic [7:0] bank_mux;

   cfg_port_ctrl #(
      .KEY_A    (KEY_A),
      .KEY_B    (KEY_B),
      .EXIT_VAL (EXIT_VAL)
   ) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .port   (bus_port),
      .wdata  (bus_wdata),
      .open   (open),
      .sel    (sel),
      .val_wr (val_wr)
   );

   assign bank_area = (sel >= BANK_FIRST);
   assign glob_wr   = val_wr && !bank_area;

   cfg_global_regs u_glob (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (glob_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .srst    (srst),
      .dev_num (dev_num),
      .gio_sel (gio_port_sel),
      .gio_en  (gio_port_en),
      .rd_data (glob_rd)
   );

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      logic bank_wr;
      assign bank_wr = val_wr && bank_area && (dev_num == 8'(d));
      cfg_dev_bank #(
         .NUM_MODE  (NUM_MODE),
         .MODE_BASE (MODE_BASE),
         .DMA_RST   (DMA_RST),
         .HAS_IRQ2  (HAS_IRQ2)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .srst    (srst),
         .wr      (bank_wr),
         .sel     (sel),
         .wdata   (bus_wdata),
         .active  (dev_active[d]),
         .base    (dev_base[d*16 +: 16]),
         .irq     (dev_irq[d*8 +: 8]),
         .irq2    (dev_irq2[d*8 +: 8]),
         .dma     (dev_dma[d*8 +: 8]),
         .mode    (dev_mode[d*MODE_W +: MODE_W]),
         .rd_data (bank_rd[d])
      );
   end

   always_comb begin
      bank_mux = 8'h00;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (dev_num == 8'(d)) bank_mux = bank_rd[d];
      end
   end

   always_comb begin
      if (!open)                  bus_rdata = 8'hFF;
      else if (bus_port == PORT_SEL) bus_rdata = sel;
      else if (bank_area)         bus_rdata = bank_mux;
      else                        bus_rdata = glob_rd;
   end

   // R3: a sealed space reads all ones on both ports
   a_r3_sealed_reads: assert property (@(posedge clk) disable iff (!rst_n)
      !open |-> (bus_rdata == 8'hFF));

   // R3: no bank output moves while sealed
   a_r3_sealed_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && $past(!open)) |-> ($stable(dev_base) && $stable(dev_active) && $stable(dev_mode)));

   // R6: an out-of-range device number leaves every bank untouched
   a_r6_oob_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (val_wr && bank_area && dev_num >= 8'(NUM_DEV)) |=> ($stable(dev_base) && $stable(dev_active)));
endmodule

// File: tb/cfg_space_top_tb.sv
module cfg_space_top_tb;
   localparam int NUM_DEV  = 9;
   localparam int NUM_MODE = 5;
   localparam int MODE_W   = NUM_MODE * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic bus_port = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [NUM_DEV-1:0]        dev_active;
   logic [NUM_DEV*16-1:0]     dev_base;
   logic [NUM_DEV*8-1:0]      dev_irq, dev_irq2, dev_dma;
   logic [NUM_DEV*MODE_W-1:0] dev_mode;
   logic [1:0] gio_port_sel;
   logic       gio_port_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   cfg_space_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_active(dev_active),
      .dev_base(dev_base), .dev_irq(dev_irq), .dev_irq2(dev_irq2),
      .dev_dma(dev_dma), .dev_mode(dev_mode), .gio_port_sel(gio_port_sel),
      .gio_port_en(gio_port_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic port, input logic [7:0] v);
      @(negedge clk);
      bus_port = port; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic port, output logic [7:0] v);
      @(negedge clk);
      bus_port = port;
      #1 v = bus_rdata;
   endtask

   task automatic unlock();
      wr(1'b0, 8'h51); wr(1'b0, 8'h23);
   endtask

   task automatic set(input logic [7:0] r, input logic [7:0] v);
      wr(1'b0, r); wr(1'b1, v);
   endtask

   task automatic get(input logic [7:0] r, output logic [7:0] v);
      wr(1'b0, r); rd(1'b1, v);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b1, v); check("R11/R3 sealed value read", v, 8'hFF);
      rd(1'b0, v); check("R3 sealed select read", v, 8'hFF);
      check("R11 active clear", dev_active, '0);
      check("R11 dma dev0", dev_dma[7:0], 8'h04);
      check("R11 dma dev8", dev_dma[8*8 +: 8], 8'h04);
      check("R11 base dev3", dev_base[3*16 +: 16], 16'h0);
   endtask

   task automatic t_broken_key();
      logic [7:0] v;
      wr(1'b0, 8'h51); wr(1'b0, 8'h00); wr(1'b0, 8'h23);
      rd(1'b0, v); check("R2 foreign byte breaks key", v, 8'hFF);
      wr(1'b0, 8'h51); wr(1'b1, 8'h23); wr(1'b0, 8'h23);
      rd(1'b0, v); check("R2 value write breaks key", v, 8'hFF);
      wr(1'b0, 8'h30); wr(1'b1, 8'h01);
      check("R3 sealed write ignored", dev_active, '0);
   endtask

   task automatic t_open();
      logic [7:0] v;
      wr(1'b0, 8'h51); wr(1'b0, 8'h51); wr(1'b0, 8'h23);
      rd(1'b0, v); check("R1/R2 repeated first byte opens, select 0", v, 8'h00);
      wr(1'b0, 8'h61);
      rd(1'b0, v); check("R5 select readback", v, 8'h61);
   endtask

   task automatic t_bank();
      logic [7:0] v;
      set(8'h07, 8'h04);
      set(8'h30, 8'hFF); set(8'h60, 8'h03); set(8'h61, 8'hF8);
      set(8'h70, 8'h04); set(8'h72, 8'h0C); set(8'h74, 8'h02);
      check("R7 active dev4", dev_active, 9'b0_0001_0000);
      check("R7 base dev4", dev_base[4*16 +: 16], 16'h03F8);
      check("R7 irq dev4", dev_irq[4*8 +: 8], 8'h04);
      check("R7 irq2 dev4", dev_irq2[4*8 +: 8], 8'h0C);
      check("R7 dma dev4", dev_dma[4*8 +: 8], 8'h02);
      check("R6 dev5 untouched", dev_base[5*16 +: 16], 16'h0);
      get(8'h30, v); check("R7 activate readback", v, 8'h01);
      get(8'h60, v); check("R5 value readback", v, 8'h03);
   endtask

   task automatic t_mode();
      logic [7:0] v;
      set(8'h07, 8'h08);
      for (int m = 0; m < NUM_MODE; m++) set(8'(8'hF0 + m), 8'(8'hA0 + m));
      for (int m = 0; m < NUM_MODE; m++)
         check("R8 mode dev8", dev_mode[(8*NUM_MODE+m)*8 +: 8], 32'(8'hA0 + m));
      get(8'hF2, v); check("R8 mode readback", v, 8'hA2);
      get(8'hF5, v); check("R8 unmapped reads zero", v, 8'h00);
      check("R6 dev4 mode untouched", dev_mode[4*MODE_W +: 8], 8'h00);
   endtask

   task automatic t_oob();
      logic [7:0] v;
      set(8'h07, 8'h09);
      set(8'h30, 8'h01); set(8'h60, 8'h55);
      check("R6 oob write dropped", dev_active, 9'b0_0001_0000);
      check("R6 oob base unchanged", dev_base[8*16 +: 16], 16'h0);
      get(8'h30, v); check("R6 oob read zero", v, 8'h00);
      get(8'h07, v); check("R6 device number readback", v, 8'h09);
   endtask

   task automatic t_global();
      logic [7:0] v;
      set(8'h03, 8'hFF);
      check("R9 port select", gio_port_sel, 2'b11);
      check("R9 port enable", gio_port_en, 1'b1);
      get(8'h03, v); check("R9 readback", v, 8'h83);
      set(8'h03, 8'h02);
      check("R9 enable cleared", {gio_port_en, gio_port_sel}, 3'b010);
   endtask

   task automatic t_exit();
      logic [7:0] v;
      wr(1'b0, 8'h60); wr(1'b0, 8'hBB);
      rd(1'b1, v); check("R4 exit seals", v, 8'hFF);
      unlock();
      rd(1'b0, v); check("R4 select kept across exit", v, 8'h60);
   endtask

   task automatic t_srst();
      logic [7:0] v;
      set(8'h02, 8'h00);
      check("R10 bit0 clear no effect", dev_active[4], 1'b1);
      get(8'h02, v); check("R10 reads zero", v, 8'h00);
      set(8'h02, 8'h01);
      check("R10 active cleared", dev_active, '0);
      check("R10 dma default", dev_dma[4*8 +: 8], 8'h04);
      check("R10 mode cleared", dev_mode[8*MODE_W +: 8], 8'h00);
      check("R10 port select cleared", gio_port_sel, 2'b00);
      get(8'h07, v); check("R10 stays open, devnum zero", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_broken_key();
      t_open();
      t_bank();
      t_mode();
      t_oob();
      t_global();
      t_exit();
      t_srst();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule